// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Packet Tags

This block sits between an HDLC deframer and the host register file. It queues received bytes until the host reads them. Next to each byte it keeps a 2-bit tag. The tag says where the byte falls in a frame and, for the last byte, whether the frame check passed. The deframer delivers a byte, its tag and a valid strobe. It also delivers a strobe when it detects a flag. Flag hunting, zero deletion and CRC checking are done upstream.

The host sees the byte at the head of the queue and its tag. A pop strobe removes that entry. A coarse 2-bit fill code summarises the queue and also carries a sticky overflow state. The host flushes the queue through a control bit that clears itself. Once flushed, the block ignores the receiver until the deframer next reports a flag.

Top module: `hdlc_rx_tag_fifo`

## Requirements
- R1: Up to 19 bytes are held in arrival order. Each byte leaves with the tag it was written with. Tag codes on `in_tag`/`head_tag`: 00 first byte, 01 packet byte, 10 last byte with good FCS, 11 last byte with bad FCS.
- R2: `fill_code` reads 00 when the queue is empty, 01 for 1 to 14 bytes and 11 for 15 or more bytes. It reads 10 whenever the overflow state is set, and this code overrides the other three.
- R3: A write accepted while 19 bytes are held, with no pop in the same cycle, is discarded and sets the overflow state. The overflow state stays set through pops and clears only on a flush.
- R4: A pop while the queue is empty changes nothing. The next byte written is the next byte popped.
- R5: A pop and an accepted write in the same cycle leave the occupancy unchanged. At 19 bytes this does not set the overflow state.
- R6: Writing 1 (`host_ctl_wr` with `host_flush_wr`=1) while `flush_pending` is 0 sets `flush_pending` on the next edge. On the edge after that, the queue empties, overflow clears and `flush_pending` returns to 0. A write of 1 while `flush_pending` is 1 has no further effect. A write of 0 has no effect.
- R7: After a flush, and after `rst_n`, byte writes are ignored until `in_flag` is seen. A byte that arrives together with `in_flag` is accepted.
- R8: In the cycle in which a flush takes effect, any byte write and any pop in that cycle are ignored.
- R9: After `rst_n` is released, `fill_code` is 00 and `flush_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the deframer |
| in_byte | input | 8 | Received byte |
| in_tag | input | 2 | Packet-position / FCS tag of the byte |
| in_flag | input | 1 | Flag-detected strobe |
| host_pop | input | 1 | Removes the head entry |
| host_ctl_wr | input | 1 | Host write strobe for the flush control bit |
| host_flush_wr | input | 1 | Value written to the flush control bit |
| head_byte | output | 8 | Byte at the head of the queue |
| head_tag | output | 2 | Tag of the head byte |
| fill_code | output | 2 | Fill / overflow code |
| flush_pending | output | 1 | Readback of the flush control bit |

## Verification
A host pop and a deframer write can land in the same cycle. The bench provokes this with the queue half full and with it completely full. It then checks that the fill code does not move, that overflow stays clear, and that the scoreboard still receives every byte in order. A flush can also coincide with a write and a pop. The bench drives both in the exact cycle the flush acts, then requires an empty code and no extra entries.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        TAG_FIRST   = 2'b00,
        TAG_BODY    = 2'b01,
        TAG_END_OK  = 2'b10,
        TAG_END_BAD = 2'b11
    } rx_tag_e;

    typedef enum logic [1:0] {
        LVL_EMPTY = 2'b00,
        LVL_LOW   = 2'b01,
        LVL_OVF   = 2'b10,
        LVL_HIGH  = 2'b11
    } lvl_e;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int DEPTH = 19,
    parameter int WIDTH = 10,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [PW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_ptr] <= wr_word;
        end
    end

    assign rd_word = slot_q[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 19,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          flag_seen,
    input  logic          rd_pop,
    input  logic          ctl_wr,
    input  logic          ctl_flush,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          flush_bit
);
    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
        logic          gate;
        logic          flush_bit;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic  take, pop_ok, full, push;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (s_q.count == CW'(DEPTH));
    assign take   = wr_valid && (!s_q.gate || flag_seen) && !s_q.flush_bit;
    assign pop_ok = rd_pop && (s_q.count != '0) && !s_q.flush_bit;
    assign push   = take && (!full || pop_ok);

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        if (s_q.flush_bit) begin
            s_d.wr_ptr    = '0;
            s_d.rd_ptr    = '0;
            s_d.count     = '0;
            s_d.ovf       = 1'b0;
            s_d.gate      = 1'b1;
            s_d.flush_bit = 1'b0;
        end else begin
            if (take && full && !pop_ok) begin
                s_d.ovf = 1'b1;
            end
            if (push) begin
                wr_en      = 1'b1;
                s_d.wr_ptr = bump(s_q.wr_ptr);
            end
            if (pop_ok) begin
                s_d.rd_ptr = bump(s_q.rd_ptr);
            end
            case ({push, pop_ok})
                2'b10:   s_d.count = s_q.count + 1'b1;
                2'b01:   s_d.count = s_q.count - 1'b1;
                default: s_d.count = s_q.count;
            endcase
            if (flag_seen) begin
                s_d.gate = 1'b0;
            end
            if (ctl_wr && ctl_flush) begin
                s_d.flush_bit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr_ptr: '0, rd_ptr: '0, count: '0, ovf: 1'b0,
                     gate: 1'b1, flush_bit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ptr    = s_q.wr_ptr;
    assign rd_ptr    = s_q.rd_ptr;
    assign count     = s_q.count;
    assign ovf       = s_q.ovf;
    assign flush_bit = s_q.flush_bit;

    // R1: occupancy never exceeds the storage depth
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    // R3: overflow state is sticky until a flush acts
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !s_q.flush_bit) |=> s_q.ovf);

    // R4: popping an empty queue leaves the read pointer alone
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && s_q.count == '0 && !s_q.flush_bit) |=> $stable(s_q.rd_ptr));

    // R5: simultaneous pop and accepted write keep the occupancy
    assert_rw_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pop_ok) |=> $stable(s_q.count));

    // R6: the flush control bit clears itself after one cycle
    assert_flush_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flush_bit |=> !s_q.flush_bit);

    // R7: while gated and no flag, nothing is stored
    assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gate && !flag_seen && !s_q.flush_bit) |=> $stable(s_q.wr_ptr));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 19,
    parameter int HIGH_MARK = 15,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          ovf,
    output logic [1:0]    lvl
);
    lvl_e lvl_d;

    always_comb begin
        if (ovf) begin
            lvl_d = LVL_OVF;
        end else if (count == '0) begin
            lvl_d = LVL_EMPTY;
        end else if (count >= CW'(HIGH_MARK)) begin
            lvl_d = LVL_HIGH;
        end else begin
            lvl_d = LVL_LOW;
        end
    end

    assign lvl = lvl_d;

    // R2: the code only reports empty when the queue truly holds nothing
    assert_empty_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'b00) |-> (count == '0 && !ovf));
endmodule

// File: rtl/hdlc_rx_tag_fifo.sv
module hdlc_rx_tag_fifo #(
    parameter int DEPTH     = 19,
    parameter int HIGH_MARK = 15,
    parameter int DW        = 8,
    parameter int TW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic [TW-1:0] in_tag,
    input  logic          in_flag,
    input  logic          host_pop,
    input  logic          host_ctl_wr,
    input  logic          host_flush_wr,
    output logic [DW-1:0] head_byte,
    output logic [TW-1:0] head_tag,
    output logic [1:0]    fill_code,
    output logic          flush_pending
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int WW = DW + TW;

    logic          wr_en, ovf;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [WW-1:0] rd_word;

    rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (in_valid),
        .flag_seen (in_flag),
        .rd_pop    (host_pop),
        .ctl_wr    (host_ctl_wr),
        .ctl_flush (host_flush_wr),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .ovf       (ovf),
        .flush_bit (flush_pending)
    );

    rxq_mem #(.DEPTH(DEPTH), .WIDTH(WW)) mem_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_word ({in_tag, in_byte}),
        .rd_ptr  (rd_ptr),
        .rd_word (rd_word)
    );

    rxq_status #(.DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK)) status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .ovf   (ovf),
        .lvl   (fill_code)
    );

    assign head_byte = rd_word[DW-1:0];
    assign head_tag  = rd_word[WW-1:DW];
endmodule

// File: tb/hdlc_rx_tag_fifo_tb_top.sv
module hdlc_rx_tag_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_flag = 1'b0, host_pop = 1'b0;
    logic       host_ctl_wr = 1'b0, host_flush_wr = 1'b0;
    logic [7:0] in_byte = '0;
    logic [1:0] in_tag = '0;
    logic [7:0] head_byte;
    logic [1:0] head_tag, fill_code;
    logic       flush_pending;

    int  checks = 0, failures = 0;
    int  mcount = 0;
    bit  movf = 0, mgate = 1, mflush = 0, mon_pop = 0;
    logic [9:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_tag_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_tag(in_tag), .in_flag(in_flag), .host_pop(host_pop),
        .host_ctl_wr(host_ctl_wr), .host_flush_wr(host_flush_wr),
        .head_byte(head_byte), .head_tag(head_tag), .fill_code(fill_code),
        .flush_pending(flush_pending)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int model_code();
        if (movf) return 2;
        if (mcount == 0) return 0;
        if (mcount >= 15) return 3;
        return 1;
    endfunction

    task automatic chk_code(input string req);
        chk(req, int'(fill_code), model_code());
    endtask

    // Driver: called at posedge+1, drives one cycle and updates the model.
    task automatic step(input bit wv, input logic [7:0] d, input logic [1:0] t,
                        input bit fl, input bit pp, input bit cw, input bit cf);
        bit take, popok, full;
        in_valid = wv; in_byte = d; in_tag = t; in_flag = fl;
        host_pop = pp; host_ctl_wr = cw; host_flush_wr = cf;
        if (mflush) begin
            exp_q.delete();
            mcount = 0; movf = 0; mgate = 1; mflush = 0;
        end else begin
            take  = wv && (!mgate || fl);
            popok = pp && (mcount > 0);
            full  = (mcount == DEPTH);
            if (popok) mon_pop = 1;
            if (take && full && !popok) movf = 1;
            if (take && (!full || popok)) begin
                exp_q.push_back({t, d});
                mcount++;
            end
            if (popok) mcount--;
            if (fl) mgate = 0;
            if (cw && cf) mflush = 1;
        end
        @(posedge clk); #1;
        mon_pop = 0;
        in_valid = 0; in_flag = 0; host_pop = 0; host_ctl_wr = 0; host_flush_wr = 0;
    endtask

    task automatic idle();
        step(0, 8'h00, 2'b00, 0, 0, 0, 0);
    endtask

    // Monitor: compares the head entry with the scoreboard before a pop edge.
    always @(negedge clk) begin
        if (mon_pop) begin
            chk("R1 head entry order/tag", int'({head_tag, head_byte}), int'(exp_q[0]));
            void'(exp_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9 reset fill code", int'(fill_code), 0);
        chk("R9 reset flush bit", int'(flush_pending), 0);

        // R7: gated after reset, flag opens the gate with that byte
        step(1, 8'hAA, 2'b00, 0, 0, 0, 0);
        chk("R7 gated byte ignored", int'(fill_code), 0);
        step(1, 8'h10, 2'b00, 1, 0, 0, 0);
        chk_code("R7 byte with flag accepted");
        chk("R2 one byte low code", int'(fill_code), 1);
        for (int i = 1; i < 14; i++) step(1, 8'h10 + 8'(i), 2'(i % 4), 0, 0, 0, 0);
        chk("R2 fourteen bytes low code", int'(fill_code), 1);
        step(1, 8'h1E, 2'b10, 0, 0, 0, 0);
        chk("R2 fifteen bytes high code", int'(fill_code), 3);
        for (int i = 15; i < 19; i++) step(1, 8'h10 + 8'(i), 2'(i % 4), 0, 0, 0, 0);
        chk("R2 full high code", int'(fill_code), 3);
        step(1, 8'hEE, 2'b11, 0, 0, 0, 0);
        chk("R3 write at full sets overflow", int'(fill_code), 2);
        for (int i = 0; i < 19; i++) step(0, 8'h00, 2'b00, 0, 1, 0, 0);
        chk("R3 overflow sticky after draining", int'(fill_code), 2);
        chk_code("R2 overflow overrides empty");

        // R6: flush sequence
        step(0, 8'h00, 2'b00, 0, 0, 1, 1);
        chk("R6 flush bit set", int'(flush_pending), 1);
        idle();
        chk("R6 flush bit self clears", int'(flush_pending), 0);
        chk("R6 flush empties and clears overflow", int'(fill_code), 0);

        // R4: pop on empty
        step(0, 8'h00, 2'b00, 1, 1, 0, 0);
        chk("R4 empty pop no effect", int'(fill_code), 0);
        step(1, 8'h55, 2'b01, 0, 0, 0, 0);
        chk("R4 one byte after empty pop", int'(fill_code), 1);
        step(0, 8'h00, 2'b00, 0, 1, 0, 0);
        chk("R4 drained again", int'(fill_code), 0);

        // R5: simultaneous pop and write, mid level and full
        for (int i = 0; i < 8; i++) step(1, 8'h40 + 8'(i), 2'(i % 4), 0, 0, 0, 0);
        step(1, 8'h60, 2'b10, 0, 1, 0, 0);
        chk("R5 mid level pop+write", int'(fill_code), 1);
        for (int i = 8; i < 19; i++) step(1, 8'h40 + 8'(i), 2'(i % 4), 0, 0, 0, 0);
        chk("R5 queue full before", int'(fill_code), 3);
        step(1, 8'h77, 2'b11, 0, 1, 0, 0);
        chk("R5 pop+write at full no overflow", int'(fill_code), 3);
        for (int i = 0; i < 19; i++) step(0, 8'h00, 2'b00, 0, 1, 0, 0);
        chk("R5 drained in order", int'(fill_code), 0);

        // R8: write and pop in the cycle the flush acts
        step(1, 8'h81, 2'b00, 0, 0, 0, 0);
        step(1, 8'h82, 2'b01, 0, 0, 0, 0);
        step(0, 8'h00, 2'b00, 0, 0, 1, 1);
        step(1, 8'h83, 2'b10, 1, 1, 0, 0);
        chk("R8 flush beats write and pop", int'(fill_code), 0);
        step(1, 8'h84, 2'b00, 0, 0, 0, 0);
        chk("R7 gated after flush", int'(fill_code), 0);

        // R6: held write of 1, and a write of 0
        step(1, 8'h91, 2'b00, 1, 0, 0, 0);
        step(0, 8'h00, 2'b00, 0, 0, 1, 1);
        step(0, 8'h00, 2'b00, 0, 0, 1, 1);
        chk("R6 held write gives one flush", int'(flush_pending), 0);
        chk("R6 flushed by held write", int'(fill_code), 0);
        step(1, 8'h92, 2'b01, 1, 0, 0, 0);
        step(0, 8'h00, 2'b00, 0, 0, 1, 0);
        repeat (3) idle();
        chk("R6 write of zero no flush", int'(flush_pending), 0);
        chk("R6 byte survives", int'(fill_code), 1);
        step(0, 8'h00, 2'b00, 0, 1, 0, 0);
        chk_code("R1 final drain");

        finish_run();
    end
endmodule